// File: doc/BRIEF.md
# Compact Floating-Point Multiplier

This block multiplies two 23-bit floating-point words and returns their product in the same 23-bit layout. Each word holds a 6-bit exponent in bits [22:17], a sign in bit 16 (1 means negative) and a 16-bit stored mantissa in bits [15:0]. A nonzero word also carries an implied leading one above the stored mantissa, so its full significand is the 17-bit value {1, MAN}. An exponent field of zero marks the value zero.

The block is a three-stage pipeline. The first stage restores the hidden ones, adds the exponents, combines the signs and flags zero operands. The second stage forms the full 34-bit unsigned significand product. The third stage picks one of two 16-bit windows of that product, corrects the exponent, and resolves underflow to zero and overflow to a saturated word. The block accepts a new operation on every clock in which `in_valid` is high. `out_valid` marks each result exactly three cycles later. There is no back-pressure, and the result is truncated.

The pipeline has no state machine. The only control state is the valid bit that travels through the three stages alongside each operation.

Top module: `fpm_mul_top`

## Requirements
- R1: `out_valid` is high exactly 3 clock cycles after a cycle in which `in_valid` was sampled high, and low otherwise. After a synchronous reset, `out_valid` is 0 and `out_prod` is 0.
- R2: The significand product P is {1, MAN_A} × {1, MAN_B}, a 34-bit unsigned value. When P bit 33 is 1, the result mantissa (bits [15:0]) is P[32:17].
- R3: When P bit 33 is 0, the result mantissa is P[31:16], and the result exponent is reduced by one more.
- R4: The result exponent (bits [22:17]) is EXP_A + EXP_B − 16, with the extra −1 from R3 when it applies.
- R5: The result sign (bit 16) is SIGN_A XOR SIGN_B for every nonzero result, including saturated results.
- R6: If either input exponent field is 0, the result word is all zeros.
- R7: If the exponent computed by R4 is 0 or negative, the result word is all zeros.
- R8: If the exponent computed by R4 exceeds 63, the result has exponent 63 and mantissa 0xFFFF.
- R9: Operations issued on consecutive cycles produce independent results on consecutive cycles.
- R10: While `out_valid` is low, `out_prod` keeps the last valid result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands present this cycle |
| in_a | input | 23 | First operand {EXP, SIGN, MAN} |
| in_b | input | 23 | Second operand {EXP, SIGN, MAN} |
| out_valid | output | 1 | Result present this cycle |
| out_prod | output | 23 | Product {EXP, SIGN, MAN} |

## Verification
Every result, whether normal, zero, underflowed or saturated, appears at the output three rising edges after its operands were sampled. `out_valid` follows the same three-edge delay. The bench drives operands on the falling edge and pushes the expected word into its own three-entry queue. On each later falling edge it shifts that queue and compares the port values with the entry that has aged three cycles. The cycles in between carry random idle gaps, which exercise the hold rule.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    localparam int FPM_EXP_W = 6;
    localparam int FPM_MAN_W = 16;

    typedef enum logic [1:0] {
        RES_NORM,
        RES_ZERO,
        RES_SAT
    } res_cls_e;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack #(
    parameter int EXP_W = fpm_pkg::FPM_EXP_W,
    parameter int MAN_W = fpm_pkg::FPM_MAN_W,
    localparam int W = EXP_W + 1 + MAN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [W-1:0]     in_a,
    input  logic [W-1:0]     in_b,
    output logic             s1_valid,
    output logic [MAN_W:0]   s1_mant [2],
    output logic [EXP_W:0]   s1_esum,
    output logic             s1_sign,
    output logic             s1_zero
);
    logic [W-1:0] ops [2];
    logic [1:0]   op_zero;

    assign ops[0] = in_a;
    assign ops[1] = in_b;

    // Restore the hidden one of each operand and flag a zero exponent.
    for (genvar i = 0; i < 2; i++) begin : g_op
        assign op_zero[i] = (ops[i][W-1 -: EXP_W] == '0);
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_mant[i] <= '0;
            end else if (in_valid) begin
                s1_mant[i] <= {1'b1, ops[i][MAN_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_esum  <= '0;
            s1_sign  <= 1'b0;
            s1_zero  <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_esum <= {1'b0, in_a[W-1 -: EXP_W]} + {1'b0, in_b[W-1 -: EXP_W]};
                s1_sign <= in_a[MAN_W] ^ in_b[MAN_W];
                s1_zero <= |op_zero;
            end
        end
    end
endmodule

// File: rtl/fpm_mant_mul.sv
module fpm_mant_mul #(
    parameter int EXP_W = fpm_pkg::FPM_EXP_W,
    parameter int MAN_W = fpm_pkg::FPM_MAN_W,
    localparam int PW = 2 * (MAN_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s1_valid,
    input  logic [MAN_W:0]   s1_mant [2],
    input  logic [EXP_W:0]   s1_esum,
    input  logic             s1_sign,
    input  logic             s1_zero,
    output logic             s2_valid,
    output logic [PW-1:0]    s2_prod,
    output logic [EXP_W:0]   s2_esum,
    output logic             s2_sign,
    output logic             s2_zero
);
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            s2_prod  <= '0;
            s2_esum  <= '0;
            s2_sign  <= 1'b0;
            s2_zero  <= 1'b0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                s2_prod <= PW'(s1_mant[0]) * PW'(s1_mant[1]);
                s2_esum <= s1_esum;
                s2_sign <= s1_sign;
                s2_zero <= s1_zero;
            end
        end
    end
endmodule

// File: rtl/fpm_normalize.sv
module fpm_normalize
    import fpm_pkg::*;
#(
    parameter int EXP_W = fpm_pkg::FPM_EXP_W,
    parameter int MAN_W = fpm_pkg::FPM_MAN_W,
    parameter int BIAS  = fpm_pkg::FPM_MAN_W,
    localparam int PW   = 2 * (MAN_W + 1),
    localparam int ES_W = EXP_W + 3,
    localparam int W    = EXP_W + 1 + MAN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s2_valid,
    input  logic [PW-1:0]    s2_prod,
    input  logic [EXP_W:0]   s2_esum,
    input  logic             s2_sign,
    input  logic             s2_zero,
    output logic             out_valid,
    output logic [W-1:0]     out_word
);
    localparam logic [ES_W-1:0] EMAX = ES_W'((1 << EXP_W) - 1);

    logic             top_set;
    logic [MAN_W-1:0] man_n;
    logic [ES_W-1:0]  e_val;
    res_cls_e         cls;
    logic [W-1:0]     nxt_word;

    always_comb begin
        top_set = s2_prod[PW-1];
        man_n   = top_set ? s2_prod[PW-2 -: MAN_W] : s2_prod[PW-3 -: MAN_W];
        e_val   = {2'b00, s2_esum} - ES_W'(BIAS) - ES_W'(!top_set);
        if (s2_zero || e_val[ES_W-1] || (e_val == '0)) begin
            cls = RES_ZERO;
        end else if (e_val > EMAX) begin
            cls = RES_SAT;
        end else begin
            cls = RES_NORM;
        end
    end

    always_comb begin
        unique case (cls)
            RES_ZERO: nxt_word = '0;
            RES_SAT:  nxt_word = {EMAX[EXP_W-1:0], s2_sign, {MAN_W{1'b1}}};
            RES_NORM: nxt_word = {e_val[EXP_W-1:0], s2_sign, man_n};
            default:  nxt_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid) begin
                out_word <= nxt_word;
            end
        end
    end
endmodule

// File: rtl/fpm_mul_top.sv
module fpm_mul_top #(
    parameter int EXP_W = fpm_pkg::FPM_EXP_W,
    parameter int MAN_W = fpm_pkg::FPM_MAN_W,
    localparam int W  = EXP_W + 1 + MAN_W,
    localparam int PW = 2 * (MAN_W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_valid,
    output logic [W-1:0] out_prod
);
    logic             s1_valid, s1_sign, s1_zero;
    logic [MAN_W:0]   s1_mant [2];
    logic [EXP_W:0]   s1_esum;
    logic             s2_valid, s2_sign, s2_zero;
    logic [PW-1:0]    s2_prod;
    logic [EXP_W:0]   s2_esum;

    fpm_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) unpack_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .s1_valid(s1_valid), .s1_mant(s1_mant), .s1_esum(s1_esum),
        .s1_sign(s1_sign), .s1_zero(s1_zero)
    );

    fpm_mant_mul #(.EXP_W(EXP_W), .MAN_W(MAN_W)) mul_i (
        .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_mant(s1_mant),
        .s1_esum(s1_esum), .s1_sign(s1_sign), .s1_zero(s1_zero),
        .s2_valid(s2_valid), .s2_prod(s2_prod), .s2_esum(s2_esum),
        .s2_sign(s2_sign), .s2_zero(s2_zero)
    );

    fpm_normalize #(.EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(MAN_W)) norm_i (
        .clk(clk), .rst(rst), .s2_valid(s2_valid), .s2_prod(s2_prod),
        .s2_esum(s2_esum), .s2_sign(s2_sign), .s2_zero(s2_zero),
        .out_valid(out_valid), .out_word(out_prod)
    );
endmodule

// File: rtl/fpm_mul_chk.sv
module fpm_mul_chk #(
    parameter int EXP_W = fpm_pkg::FPM_EXP_W,
    parameter int MAN_W = fpm_pkg::FPM_MAN_W,
    localparam int W = EXP_W + 1 + MAN_W
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] in_a,
    input logic [W-1:0] in_b,
    input logic         out_valid,
    input logic [W-1:0] out_prod
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));  // R1

    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
        ((age == 2'd3) && $past(in_valid, 3) &&
         (($past(in_a[W-1 -: EXP_W], 3) == '0) || ($past(in_b[W-1 -: EXP_W], 3) == '0)))
        |-> (out_prod == '0));  // R6

    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_prod[W-1 -: EXP_W] == '0)) |-> (out_prod == '0));  // R7

    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst)
        ((age == 2'd3) && out_valid && (out_prod[W-1 -: EXP_W] != '0))
        |-> (out_prod[MAN_W] == ($past(in_a[MAN_W], 3) ^ $past(in_b[MAN_W], 3))));  // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_prod));  // R10
endmodule

bind fpm_mul_top fpm_mul_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_prod(out_prod)
);

// File: tb/fpm_mul_top_tb_top.sv
module fpm_mul_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [22:0] in_a = '0;
    logic [22:0] in_b = '0;
    logic        out_valid;
    logic [22:0] out_prod;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        p_v [3];
    logic [22:0] p_w [3];
    string       p_t [3];
    logic [22:0] last_out = '0;

    always #10 clk = ~clk;

    fpm_mul_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_prod(out_prod)
    );

    function automatic logic [22:0] ref_mul(logic [22:0] a, logic [22:0] b);
        logic [33:0] p;
        int e;
        logic s;
        logic [15:0] m;
        if (a[22:17] == 0 || b[22:17] == 0) return '0;
        p = 34'({1'b1, a[15:0]}) * 34'({1'b1, b[15:0]});
        s = a[16] ^ b[16];
        m = p[33] ? p[32:17] : p[31:16];
        e = int'(a[22:17]) + int'(b[22:17]) - 16 - (p[33] ? 0 : 1);
        if (e <= 0) return '0;
        if (e > 63) return {6'h3f, s, 16'hffff};
        return {e[5:0], s, m};
    endfunction

    function automatic string tag_of(logic [22:0] a, logic [22:0] b);
        logic [33:0] p;
        int e;
        if (a[22:17] == 0 || b[22:17] == 0) return "R6";
        p = 34'({1'b1, a[15:0]}) * 34'({1'b1, b[15:0]});
        e = int'(a[22:17]) + int'(b[22:17]) - 16 - (p[33] ? 0 : 1);
        if (e <= 0) return "R7";
        if (e > 63) return "R8/R5";
        return p[33] ? "R2/R4/R5" : "R3/R4/R5";
    endfunction

    task automatic step(input logic v, input logic [22:0] a, input logic [22:0] b);
        @(negedge clk);
        checks++;
        if (out_valid !== p_v[2]) begin
            errors++;
            $display("FAIL R1/R9 out_valid actual=%0b expected=%0b", out_valid, p_v[2]);
        end
        if (p_v[2]) begin
            checks++;
            if (out_prod !== p_w[2]) begin
                errors++;
                $display("FAIL %s a/b result actual=%h expected=%h", p_t[2], out_prod, p_w[2]);
            end
            last_out = p_w[2];
        end else begin
            checks++;
            if (out_prod !== last_out) begin
                errors++;
                $display("FAIL R10 hold actual=%h expected=%h", out_prod, last_out);
            end
        end
        p_v[2] = p_v[1]; p_w[2] = p_w[1]; p_t[2] = p_t[1];
        p_v[1] = p_v[0]; p_w[1] = p_w[0]; p_t[1] = p_t[0];
        p_v[0] = v;
        p_w[0] = v ? ref_mul(a, b) : '0;
        p_t[0] = tag_of(a, b);
        in_valid = v;
        in_a = a;
        in_b = b;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            p_v[i] = 1'b0; p_w[i] = '0; p_t[i] = "R1";
        end
        void'($urandom(32'd24681));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || out_prod !== '0) begin
            errors++;
            $display("FAIL R1 reset actual=%0b/%h expected=0/000000", out_valid, out_prod);
        end
        // Directed corners
        step(1, {6'd20, 1'b0, 16'h0000}, {6'd20, 1'b0, 16'h0000}); // R3: 1.0*1.0
        step(1, {6'd20, 1'b1, 16'hffff}, {6'd20, 1'b0, 16'hffff}); // R2: top bit set
        step(1, {6'd0,  1'b1, 16'h1234}, {6'd30, 1'b0, 16'h5678}); // R6
        step(1, {6'd30, 1'b0, 16'h1234}, {6'd0,  1'b1, 16'h5678}); // R6
        step(1, {6'd9,  1'b1, 16'h0000}, {6'd8,  1'b0, 16'h0000}); // R7: exponent 0
        step(1, {6'd9,  1'b1, 16'h0000}, {6'd9,  1'b0, 16'h0000}); // R4: exponent 1
        step(1, {6'd1,  1'b0, 16'h8000}, {6'd1,  1'b0, 16'h8000}); // R7: negative
        step(1, {6'd40, 1'b0, 16'hffff}, {6'd39, 1'b1, 16'hffff}); // R4: exponent 63
        step(1, {6'd40, 1'b1, 16'hffff}, {6'd40, 1'b0, 16'hffff}); // R8: exponent 64
        step(1, {6'd63, 1'b1, 16'h0001}, {6'd63, 1'b1, 16'h0002}); // R8
        step(0, '1, '1);                                            // R10 idle
        step(0, 23'h155555, 23'h2aaaaa);                            // R10 idle
        step(1, {6'd33, 1'b1, 16'h8000}, {6'd17, 1'b1, 16'h7fff}); // R5
        // Constrained random, mostly back-to-back (R9)
        for (int k = 0; k < 600; k++) begin
            logic v;
            logic [22:0] a;
            logic [22:0] b;
            v = ($urandom % 5) != 0;
            a = 23'($urandom);
            b = 23'($urandom);
            if (($urandom % 10) == 0) a[22:17] = '0;
            step(v, a, b);
        end
        for (int k = 0; k < 4; k++) step(0, '0, '0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule